// File: doc/BRIEF.md
# MIDI Receive Queue Controller

This block is the MIDI side of a sound controller as a byte-wide register view presents it. Incoming MIDI bytes land in a circular byte queue. They arrive either as short messages or as a system-exclusive block. The host removes bytes one at a time through a data port.

A control byte selects between a receive mode and a transmit mode. It can also trigger a software reset. A status byte reports ready and interrupt flags for each direction, and a single interrupt request follows the mode that is active. A 32-bit window register holds the most recently removed byte together with a valid flag. Any write to the window drops that flag.

Serial bit timing, the transmit data path and address decoding belong to the surrounding logic. The strobes on this block's ports stand for decoded register accesses.

Top module: `midi_rxq`

## Requirements
- R1: While reset is held, the outputs read as follows: `ctrl_q`=0x00, `status_q`=0x00, `win_q`=0, `irq`=0, and `data_q`=0. The block is in transmit mode with an empty queue (both pointers 0), and every queue entry is 0.
- R2: In receive mode, with `sx_busy` low, a cycle with `sm_valid` high has these effects:
  - `sm_byte` is stored at the write pointer, and the write pointer advances modulo DEPTH (default 64).
  - Status bit 0 (receive ready) and status bit 2 (receive interrupt) are set.
  - The valid flag is set.
- R3: In receive mode, `data_q` shows the entry at the read pointer. A `data_rd` cycle then does the following:
  - The shown byte is latched as the last byte.
  - The read pointer advances only if it differs from the write pointer.
  - Status bits 0 and 2 are cleared.
  - The UART interrupt status is cleared if the valid flag is clear.
  Outside receive mode, `data_q` is 0 and `data_rd` has no effect.
- R4: `ctrl_q` keeps only the written bits under mask 0xE3.
- R5: A control write with bits [1:0] both 1 is a software reset. It leaves receive mode, clears the status byte, both pointers and the valid flag, and keeps the last byte.
- R6: Any other control write with bit 7 (receive interrupt enable) set enters receive mode. A control write with bit 7 clear and bits [6:5] (transmit interrupt field) not equal to 2'b01 leaves receive mode and clears the UART interrupt status. A write with bit 7 clear and bits [6:5]=2'b01 keeps the current mode.
- R7: In every cycle spent outside receive mode, status bit 1 (transmit ready) and bit 3 (transmit interrupt) are set, and bits 0 and 2 are cleared. In every cycle spent in receive mode, bits 1 and 3 are cleared.
- R8: `win_q` returns the last byte in bits [7:0] and the valid flag in bit 8; all higher bits are 0. A `win_wr` cycle clears the valid flag unless a short message is stored in the same cycle.
- R9: The interrupt condition depends on the mode.
  - In receive mode, it holds when control bit 7 and status bit 2 are both set.
  - Outside receive mode, it holds when control bits [6:5] are not 2'b01 and status bit 3 is set.
  `irq` is high when the sticky UART interrupt status and the condition are both true.
- R10: The UART interrupt status becomes set only in a cycle after `irq_en` was high with the condition true. While `irq_en` stays low from reset, `irq` stays 0.
- R11: While `sx_busy` is high, short messages are ignored. A `sx_valid` byte is stored and the write pointer advances only while the pointers differ (`sx_ready` high). System-exclusive bytes leave the status byte and the valid flag unchanged.
- R12: A short message that arrives outside receive mode is neither stored nor reflected in the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_en | input | 1 | Allows the UART interrupt status to become set |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write value |
| ctrl_q | output | 8 | Control byte read value |
| status_q | output | 8 | Status byte: bit0 rx ready, bit1 tx ready, bit2 rx int, bit3 tx int |
| data_rd | input | 1 | Data port read strobe (pops in receive mode) |
| data_q | output | DW | Data port read value |
| win_wr | input | 1 | Window register write strobe |
| win_q | output | WIN_W | Window register read value |
| sm_valid | input | 1 | Short-message byte strobe |
| sm_byte | input | DW | Short-message byte |
| sx_busy | input | 1 | System-exclusive transfer in progress |
| sx_valid | input | 1 | System-exclusive byte strobe |
| sx_byte | input | DW | System-exclusive byte |
| sx_ready | output | 1 | Read and write pointers differ |
| irq | output | 1 | UART interrupt request |

## Verification
The bench drives several input patterns, and each one separates a different kind of fault:
- A three-byte short message followed by pops tells storage order apart from pointer stepping.
- A pop of an empty queue, followed by a fresh byte, shows whether the read pointer was held.
- A 2-byte-plus-61-byte system-exclusive fill reads back 63 computed values across the wrap point, which separates modulo arithmetic from saturating or off-by-one pointers.
- A one-byte-plus-66-byte overfill must stop with equal pointers. Two identical pops then distinguish the early stop from a queue that kept storing.
- Mode and interrupt patterns cover each value of the transmit field, both modes and `irq_en` low and high, so that the mode-dependent interrupt selection cannot collapse to a single case.

// File: rtl/midi_rxq_pkg.sv
package midi_rxq_pkg;
   localparam int ST_RXRDY = 0;
   localparam int ST_TXRDY = 1;
   localparam int ST_RXINT = 2;
   localparam int ST_TXINT = 3;
   localparam int CTL_RXIE = 7;
   localparam logic [7:0] CTL_MASK = 8'hE3;
   localparam logic [1:0] TX_FIELD_OFF = 2'b01;

   typedef enum logic {
      MODE_TX = 1'b0,
      MODE_RX = 1'b1
   } uart_mode_e;
endpackage

// File: rtl/midi_rxq_ring.sv
module midi_rxq_ring #(
   parameter int DEPTH = 64,
   parameter int DW = 8,
   parameter bit RESET_STORAGE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          wen,
   input  logic [DW-1:0] wbyte,
   input  logic          ren,
   output logic [DW-1:0] head,
   output logic          ptr_ne
);
   localparam int AW = $clog2(DEPTH);

   logic [AW-1:0] rptr, wptr;
   logic [DW-1:0] mem [DEPTH];

   initial begin
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         $error("midi_rxq_ring: DEPTH must be a power of two");
      if (DW < 1)
         $error("midi_rxq_ring: DW must be positive");
   end

   assign head   = mem[rptr];
   assign ptr_ne = (rptr != wptr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rptr <= '0;
         wptr <= '0;
      end else if (clr) begin
         rptr <= '0;
         wptr <= '0;
      end else begin
         if (wen)
            wptr <= wptr + AW'(1);
         if (ren && ptr_ne)
            rptr <= rptr + AW'(1);
      end
   end

   generate
      if (RESET_STORAGE) begin : g_rst_store
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++)
                  mem[i] <= '0;
            end else if (wen && !clr) begin
               mem[wptr] <= wbyte;
            end
         end
      end else begin : g_plain_store
         always_ff @(posedge clk) begin
            if (wen && !clr)
               mem[wptr] <= wbyte;
         end
      end
   endgenerate

   // R3: a pop of an empty-looking queue leaves the head where it was
   a_r3_hold_equal: assert property (@(posedge clk) disable iff (!rst_n)
      (ren && !ptr_ne && !clr && !wen) |=> $stable(head));

   // R2: the write pointer wraps to zero after the last slot
   a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (wen && !clr && wptr == AW'(DEPTH - 1)) |=> (wptr == '0));
endmodule

// File: rtl/midi_rxq_win.sv
module midi_rxq_win #(
   parameter int DW = 8,
   parameter int WW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          take,
   input  logic [DW-1:0] take_byte,
   input  logic          mark,
   input  logic          wr,
   output logic          valid,
   output logic [WW-1:0] rdata
);
   logic [DW-1:0] last;

   initial begin
      if (WW <= DW)
         $error("midi_rxq_win: WW must exceed DW");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last  <= '0;
         valid <= 1'b0;
      end else begin
         if (take)
            last <= take_byte;
         if (clr)
            valid <= 1'b0;
         else if (mark)
            valid <= 1'b1;
         else if (wr)
            valid <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      rdata[DW:0] = {valid, last};
   end

   // R8: a window write with no message stored alongside drops the flag
   a_r8_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !mark) |=> !rdata[DW]);
endmodule

// File: rtl/midi_rxq_ctl.sv
module midi_rxq_ctl
   import midi_rxq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       irq_en,
   input  logic       ctrl_wr,
   input  logic [7:0] ctrl_wdata,
   input  logic       pop,
   input  logic       push,
   input  logic       valid,
   output logic [7:0] ctrl,
   output logic [7:0] status,
   output logic       rx_mode,
   output logic       soft_rst,
   output logic       irq
);
   uart_mode_e mode;
   logic       ist;
   logic       enter_rx, leave_rx, cond, ist_clr;
   logic [7:0] st_nx;

   assign rx_mode  = (mode == MODE_RX);
   assign soft_rst = ctrl_wr && (&ctrl_wdata[1:0]);
   assign enter_rx = ctrl_wr && !soft_rst && ctrl_wdata[CTL_RXIE];
   assign leave_rx = ctrl_wr && !soft_rst && !ctrl_wdata[CTL_RXIE]
                     && (ctrl_wdata[6:5] != TX_FIELD_OFF);
   assign cond     = rx_mode ? (ctrl[CTL_RXIE] && status[ST_RXINT])
                             : ((ctrl[6:5] != TX_FIELD_OFF) && status[ST_TXINT]);
   assign ist_clr  = leave_rx || (pop && !valid);
   assign irq      = ist && cond;

   always_comb begin
      st_nx = status;
      if (rx_mode) begin
         st_nx[ST_TXRDY] = 1'b0;
         st_nx[ST_TXINT] = 1'b0;
      end else begin
         st_nx[ST_TXRDY] = 1'b1;
         st_nx[ST_TXINT] = 1'b1;
         st_nx[ST_RXRDY] = 1'b0;
         st_nx[ST_RXINT] = 1'b0;
      end
      if (pop) begin
         st_nx[ST_RXRDY] = 1'b0;
         st_nx[ST_RXINT] = 1'b0;
      end
      if (push) begin
         st_nx[ST_RXRDY] = 1'b1;
         st_nx[ST_RXINT] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl   <= '0;
         status <= '0;
         mode   <= MODE_TX;
         ist    <= 1'b0;
      end else if (soft_rst) begin
         ctrl   <= ctrl_wdata & CTL_MASK;
         status <= '0;
         mode   <= MODE_TX;
      end else begin
         if (ctrl_wr)
            ctrl <= ctrl_wdata & CTL_MASK;
         if (enter_rx)
            mode <= MODE_RX;
         else if (leave_rx)
            mode <= MODE_TX;
         status <= st_nx;
         ist    <= ist_clr ? 1'b0 : (ist || (irq_en && cond));
      end
   end

   // R5: software reset empties status and returns to transmit mode
   a_r5_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (status == 8'h00 && !rx_mode));

   // R10: interrupt status only becomes set after irq_en was high
   a_r10_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ist) |-> $past(irq_en));

   // R4: unmasked control bits never appear
   a_r4_mask: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> ((ctrl & ~CTL_MASK) == 8'h00));

   // R3: a pop without a simultaneous store clears the receive flags
   a_r3_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !soft_rst) |=> (!status[ST_RXRDY] && !status[ST_RXINT]));

   // R6: receive interrupt enable in a control write selects receive mode
   a_r6_enter: assert property (@(posedge clk) disable iff (!rst_n)
      enter_rx |=> rx_mode);
endmodule

// File: rtl/midi_rxq.sv
module midi_rxq
   import midi_rxq_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int DW = 8,
   parameter int WIN_W = 32,
   parameter bit RESET_STORAGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_en,
   input  logic             ctrl_wr,
   input  logic [7:0]       ctrl_wdata,
   output logic [7:0]       ctrl_q,
   output logic [7:0]       status_q,
   input  logic             data_rd,
   output logic [DW-1:0]    data_q,
   input  logic             win_wr,
   output logic [WIN_W-1:0] win_q,
   input  logic             sm_valid,
   input  logic [DW-1:0]    sm_byte,
   input  logic             sx_busy,
   input  logic             sx_valid,
   input  logic [DW-1:0]    sx_byte,
   output logic             sx_ready,
   output logic             irq
);
   logic          rx_mode, soft_rst, valid;
   logic          sm_ok, sx_ok, pop_fire, wen, ptr_ne;
   logic [DW-1:0] head, wbyte;

   assign sm_ok    = sm_valid && !sx_busy && rx_mode;
   assign sx_ok    = sx_busy && sx_valid && ptr_ne;
   assign wen      = sm_ok || sx_ok;
   assign wbyte    = sx_busy ? sx_byte : sm_byte;
   assign pop_fire = data_rd && rx_mode;
   assign data_q   = rx_mode ? head : '0;
   assign sx_ready = ptr_ne;

   midi_rxq_ring #(
      .DEPTH(DEPTH), .DW(DW), .RESET_STORAGE(RESET_STORAGE)
   ) u_ring (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst), .wen(wen), .wbyte(wbyte),
      .ren(pop_fire), .head(head), .ptr_ne(ptr_ne)
   );

   midi_rxq_win #(
      .DW(DW), .WW(WIN_W)
   ) u_win (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst), .take(pop_fire),
      .take_byte(head), .mark(sm_ok), .wr(win_wr), .valid(valid), .rdata(win_q)
   );

   midi_rxq_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .ctrl_wr(ctrl_wr),
      .ctrl_wdata(ctrl_wdata), .pop(pop_fire), .push(sm_ok), .valid(valid),
      .ctrl(ctrl_q), .status(status_q), .rx_mode(rx_mode),
      .soft_rst(soft_rst), .irq(irq)
   );

   // R11: system-exclusive traffic never raises the receive ready flag
   a_r11_sysex_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (sx_busy && !ctrl_wr && !data_rd) |=> !$rose(status_q[ST_RXRDY]));

   // R12: outside receive mode a short message leaves receive flags low
   a_r12_tx_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_mode && !ctrl_wr && sm_valid) |=> !status_q[ST_RXINT]);
endmodule

// File: tb/midi_rxq_bench.sv
`timescale 1ns/1ps
module midi_rxq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_en = 1'b0;
   logic        ctrl_wr = 1'b0;
   logic [7:0]  ctrl_wdata = '0;
   logic [7:0]  ctrl_q, status_q, data_q;
   logic        data_rd = 1'b0;
   logic        win_wr = 1'b0;
   logic [31:0] win_q;
   logic        sm_valid = 1'b0;
   logic [7:0]  sm_byte = '0;
   logic        sx_busy = 1'b0;
   logic        sx_valid = 1'b0;
   logic [7:0]  sx_byte = '0;
   logic        sx_ready, irq;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   midi_rxq u_midi_rxq (
      .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .ctrl_wr(ctrl_wr),
      .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q), .status_q(status_q),
      .data_rd(data_rd), .data_q(data_q), .win_wr(win_wr), .win_q(win_q),
      .sm_valid(sm_valid), .sm_byte(sm_byte), .sx_busy(sx_busy),
      .sx_valid(sx_valid), .sx_byte(sx_byte), .sx_ready(sx_ready), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctrl(input logic [7:0] v);
      ctrl_wr = 1'b1; ctrl_wdata = v;
      @(negedge clk);
      ctrl_wr = 1'b0;
   endtask

   task automatic send_sm(input logic [7:0] b);
      sm_valid = 1'b1; sm_byte = b;
      @(negedge clk);
      sm_valid = 1'b0;
   endtask

   task automatic send_sx(input logic [7:0] b);
      sx_valid = 1'b1; sx_byte = b;
      @(negedge clk);
      sx_valid = 1'b0;
   endtask

   task automatic pop_expect(input string tag, input logic [7:0] exp);
      chk(tag, {24'h0, data_q}, {24'h0, exp});
      data_rd = 1'b1;
      @(negedge clk);
      data_rd = 1'b0;
      chk(tag, {24'h0, win_q[7:0]}, {24'h0, exp});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      idle(3);
      // R1 reset state
      chk("R1 ctrl", {24'h0, ctrl_q}, 32'h00);
      chk("R1 status", {24'h0, status_q}, 32'h00);
      chk("R1 win", win_q, 32'h0);
      chk("R1 irq", {31'h0, irq}, 32'h0);
      chk("R1 data", {24'h0, data_q}, 32'h00);
      rst_n = 1'b1;
      idle(3);
      chk("R7 tx status", {24'h0, status_q}, 32'h0A);
      chk("R10 irq gated", {31'h0, irq}, 32'h0);
      irq_en = 1'b1;
      idle(3);
      chk("R9 tx irq", {31'h0, irq}, 32'h1);
      wr_ctrl(8'h1C);
      chk("R4 mask", {24'h0, ctrl_q}, 32'h00);
      wr_ctrl(8'h20);
      idle(3);
      chk("R9 tx field off", {31'h0, irq}, 32'h0);
      send_sm(8'h66);
      idle(2);
      chk("R12 status", {24'h0, status_q}, 32'h0A);
      chk("R3 data tx", {24'h0, data_q}, 32'h00);
      wr_ctrl(8'hC0);
      idle(3);
      chk("R6 ctrl", {24'h0, ctrl_q}, 32'hC0);
      chk("R7 rx status", {24'h0, status_q}, 32'h00);
      chk("R9 rx idle irq", {31'h0, irq}, 32'h0);
      send_sm(8'h90); send_sm(8'h3C); send_sm(8'h7F);
      idle(3);
      chk("R2 status", {24'h0, status_q}, 32'h05);
      chk("R8 win valid", win_q, 32'h100);
      chk("R9 rx irq", {31'h0, irq}, 32'h1);
      pop_expect("R3 pop0", 8'h90);
      chk("R3 status cleared", {24'h0, status_q}, 32'h00);
      chk("R8 win after pop", win_q, 32'h190);
      idle(1);
      chk("R9 irq after pop", {31'h0, irq}, 32'h0);
      pop_expect("R3 pop1", 8'h3C);
      pop_expect("R3 pop2", 8'h7F);
      pop_expect("R3 empty pop", 8'h00);
      send_sm(8'h11);
      pop_expect("R3 held ptr", 8'h11);
      win_wr = 1'b1;
      @(negedge clk);
      win_wr = 1'b0;
      chk("R8 win cleared", win_q, 32'h011);
      wr_ctrl(8'h40);
      idle(3);
      chk("R6 leave rx", {24'h0, status_q}, 32'h0A);
      chk("R3 data in tx", {24'h0, data_q}, 32'h00);
      data_rd = 1'b1;
      @(negedge clk);
      data_rd = 1'b0;
      chk("R3 tx pop ignored", win_q, 32'h011);
      wr_ctrl(8'h80);
      idle(2);
      sx_busy = 1'b1;
      send_sm(8'h55);
      idle(2);
      chk("R11 short ignored", {24'h0, status_q}, 32'h00);
      sx_busy = 1'b0;
      send_sm(8'h21); send_sm(8'h22);
      sx_busy = 1'b1;
      for (int k = 0; k < 61; k++) send_sx(8'(8'h40 + k));
      sx_busy = 1'b0;
      chk("R11 ready", {31'h0, sx_ready}, 32'h1);
      pop_expect("R2 sweep a", 8'h21);
      pop_expect("R2 sweep b", 8'h22);
      for (int k = 0; k < 61; k++) pop_expect("R2 wrap sweep", 8'(8'h40 + k));
      wr_ctrl(8'h03);
      chk("R5 ctrl", {24'h0, ctrl_q}, 32'h03);
      chk("R5 status", {24'h0, status_q}, 32'h00);
      chk("R5 win", win_q, 32'h07C);
      chk("R5 data", {24'h0, data_q}, 32'h00);
      wr_ctrl(8'h80);
      send_sm(8'hA0);
      sx_busy = 1'b1;
      for (int k = 0; k < 66; k++) send_sx(8'(8'hB0 + k));
      sx_busy = 1'b0;
      chk("R11 stopped", {31'h0, sx_ready}, 32'h0);
      pop_expect("R11 first", 8'hA0);
      pop_expect("R11 no advance", 8'hA0);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule